// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks the memory addresses of loads that a compiler has hoisted above earlier stores that might alias them. When such an early load issues, it records the doubleword it read, keyed by its destination register. Every store then searches all live records and deletes any that fall in the doubleword it writes. When the program reaches the point where the load originally stood, a check operation looks up the same register. If the record is still there, nothing wrote the location in the meantime and the early value is kept. If the record is gone, the check raises a reload request so the load is issued again.

The table holds a fixed number of records, 16 by default, and keeps at most one per register. When all slots are taken, a new record displaces the oldest one. That is always safe, because the only effect is a reload at the later check. A check removes the record it looks up, whether or not it hits.

The insert, store and check ports each take one operation per cycle and carry no back-pressure: a valid pulse is always accepted in the cycle it appears. The response port has no ready input either. A response is presented for exactly one cycle and must be taken then.

When operations meet in the same cycle, they take effect in this order:
1. store kill;
2. check;
3. insert.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table is empty: no response is presented, and a check on any register reports a miss.
- R2: A check on a register with a live record reports hit (`rsp_hit`=1, `reload_req`=0) one cycle after `chk_valid`.
- R3: A check on a register with no record reports a miss (`rsp_hit`=0, `reload_req`=1).
- R4: A store whose address matches a record in bits [ADDR_W-1:3] deletes that record. A store that differs in any of those bits leaves the record alone, whatever address bits [2:0] hold.
- R5: A check deletes the record it examined, so a second check on the same register misses.
- R6: A new insert to a register that already has a record replaces it. Only the new address is then subject to store kills, and at most one record exists per register.
- R7: With all 16 slots live, an insert to a new register evicts the oldest record; all other records remain.
- R8: A store and an insert to the same doubleword in the same cycle act store first, so the new record survives.
- R9: A store and a check in the same cycle act store first, so a check on a just-killed record misses.
- R10: A check and an insert to the same register in the same cycle report on the older record, and the inserted record remains for a later check.
- R11: `rsp_valid` is high exactly one cycle after each `chk_valid` and never otherwise, and `rsp_reg` returns the checked register.
- R12: A slot freed by a check or a kill is reused before any eviction, so a full table minus one slot takes one insert without losing a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Record an early load this cycle |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address read by the early load |
| st_valid | input | 1 | Store probe this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_reg | input | REG_W | Register being checked |
| rsp_valid | output | 1 | Check response present |
| rsp_hit | output | 1 | Record was found; early value stands |
| rsp_reg | output | REG_W | Register the response belongs to |
| reload_req | output | 1 | Record was missing; reissue the load |

## Verification
Each check response is due one cycle after the check is presented. The bench tags every expected response with the cycle in which it is due. In every cycle it either compares the response against the queued entry due then, or confirms that no response appears.

Store and insert operations have no output of their own. Their effect is observed through the next check, so same-cycle orderings are checked by placing the check either in that cycle or one cycle later. Eviction is judged by checking the displaced register and its neighbours once the table has been filled.

// File: rtl/spec_addr_pkg.sv
package spec_addr_pkg;
  // Registered outcome of a check operation.
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/spec_addr_match.sv
// Per-slot comparators for store, check and insert probes.
module spec_addr_match #(
  parameter int DEPTH = 16,
  parameter int REG_W = 7,
  parameter int TAG_W = 29
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][REG_W-1:0] slot_reg,
  input  logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
  input  logic                        st_valid,
  input  logic [TAG_W-1:0]            st_tag,
  input  logic                        chk_valid,
  input  logic [REG_W-1:0]            chk_reg,
  input  logic                        ins_valid,
  input  logic [REG_W-1:0]            ins_reg,
  output logic [DEPTH-1:0]            st_kill,
  output logic [DEPTH-1:0]            chk_take,
  output logic [DEPTH-1:0]            ins_same
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign st_kill[i]  = st_valid  & valid[i] & (slot_tag[i] == st_tag);
    assign chk_take[i] = chk_valid & valid[i] & (slot_reg[i] == chk_reg);
    assign ins_same[i] = ins_valid & valid[i] & (slot_reg[i] == ins_reg);
  end
endmodule

// File: rtl/spec_addr_age.sv
// Pairwise age matrix: older_q[i][j] set means slot i was written before slot j.
module spec_addr_age #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_we,
  input  logic [DEPTH-1:0] ins_slot,
  input  logic [DEPTH-1:0] surv,
  output logic [DEPTH-1:0] oldest
);
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (ins_we) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (ins_slot[i])
            older_q[i][j] <= 1'b0;
          else if (ins_slot[j])
            older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  // A surviving slot is oldest when it is older than every other survivor.
  for (genvar i = 0; i < DEPTH; i++) begin : g_old
    localparam logic [DEPTH-1:0] SELF = DEPTH'(1) << i;
    assign oldest[i] = surv[i] & (&(~surv | older_q[i] | SELF));
  end

  // Two live slots must always be strictly ordered.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ai
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_aj
      AST_AGE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (surv[i] && surv[j]) |-> (older_q[i][j] != older_q[j][i])); // R7
    end
  end
endmodule

// File: rtl/spec_addr_pick.sv
// Chooses the slot an insert writes: same-register slot, else lowest free, else oldest.
module spec_addr_pick #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0] surv,
  input  logic [DEPTH-1:0] same_live,
  input  logic [DEPTH-1:0] oldest,
  output logic [DEPTH-1:0] slot
);
  logic [DEPTH-1:0] free_first;

  always_comb begin
    free_first = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!surv[i]) free_first = DEPTH'(1) << i;
    end
  end

  always_comb begin
    if (|same_live)       slot = same_live;
    else if (|free_first) slot = free_first;
    else                  slot = oldest;
  end
endmodule

// File: rtl/spec_addr_table.sv
module spec_addr_table
  import spec_addr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int LINE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [REG_W-1:0]  rsp_reg,
  output logic              reload_req
);
  localparam int TAG_W = ADDR_W - LINE_LOG2;

  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][REG_W-1:0] reg_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;

  logic [DEPTH-1:0] st_kill, chk_take, ins_same, surv, oldest, slot;
  logic             chk_found;
  rsp_kind_e        rsp_q;
  logic [REG_W-1:0] rsp_reg_q;

  spec_addr_match #(.DEPTH(DEPTH), .REG_W(REG_W), .TAG_W(TAG_W)) i_match (
    .valid    (valid_q),
    .slot_reg (reg_q),
    .slot_tag (tag_q),
    .st_valid (st_valid),
    .st_tag   (st_addr[ADDR_W-1:LINE_LOG2]),
    .chk_valid(chk_valid),
    .chk_reg  (chk_reg),
    .ins_valid(ins_valid),
    .ins_reg  (ins_reg),
    .st_kill  (st_kill),
    .chk_take (chk_take),
    .ins_same (ins_same)
  );

  // Store acts first, then the check, then the insert.
  assign surv      = valid_q & ~st_kill & ~chk_take;
  assign chk_found = |(chk_take & ~st_kill);

  spec_addr_age #(.DEPTH(DEPTH)) i_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_we  (ins_valid),
    .ins_slot(slot),
    .surv    (surv),
    .oldest  (oldest)
  );

  spec_addr_pick #(.DEPTH(DEPTH)) i_pick (
    .surv     (surv),
    .same_live(ins_same & surv),
    .oldest   (oldest),
    .slot     (slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= surv | (ins_valid ? slot : '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_valid && slot[i]) begin
        reg_q[i] <= ins_reg;
        tag_q[i] <= ins_addr[ADDR_W-1:LINE_LOG2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q     <= RSP_IDLE;
      rsp_reg_q <= '0;
    end else begin
      rsp_q     <= !chk_valid ? RSP_IDLE : (chk_found ? RSP_HIT : RSP_MISS);
      rsp_reg_q <= chk_reg;
    end
  end

  assign rsp_valid  = (rsp_q != RSP_IDLE);
  assign rsp_hit    = (rsp_q == RSP_HIT);
  assign reload_req = (rsp_q == RSP_MISS);
  assign rsp_reg    = rsp_reg_q;

  // Assertion support: duplicate registers and presence of the answered register.
  logic dup_reg, rsp_reg_live;
  always_comb begin
    dup_reg      = 1'b0;
    rsp_reg_live = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && reg_q[i] == rsp_reg_q) rsp_reg_live = 1'b1;
      for (int j = i + 1; j < DEPTH; j++) begin
        if (valid_q[i] && valid_q[j] && reg_q[i] == reg_q[j]) dup_reg = 1'b1;
      end
    end
  end

  AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_reg); // R6
  AST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid); // R11
  AST_RSP_ONLY_AFTER_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(chk_valid)); // R11
  AST_CHECK_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_reg_live || $past(ins_valid && ins_reg == chk_reg))); // R5
endmodule

// File: tb/test_spec_addr_table.sv
`timescale 1ns/1ps
module test_spec_addr_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [6:0]  ins_reg = '0, chk_reg = '0;
  logic [31:0] ins_addr = '0, st_addr = '0;
  logic        rsp_valid, rsp_hit, reload_req;
  logic [6:0]  rsp_reg;

  always #2.5 clk = ~clk;

  spec_addr_table i_spec_addr_table (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reg(rsp_reg),
    .reload_req(reload_req)
  );

  typedef struct {
    int       due;
    bit       hit;
    bit [6:0] rg;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0, n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the due response, or require silence.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (!(rsp_valid && rsp_hit == e.hit && rsp_reg == e.rg && reload_req == !e.hit)) begin
          n_fail++;
          $display("FAIL %s: valid=%0b hit=%0b reg=%0d reload=%0b, expected valid=1 hit=%0b reg=%0d reload=%0b",
                   e.tag, rsp_valid, rsp_hit, rsp_reg, reload_req, e.hit, e.rg, !e.hit);
        end
      end else begin
        n_run++;
        if (rsp_valid) begin
          n_fail++;
          $display("FAIL R11: unexpected response valid=%0b reg=%0d, expected valid=0", rsp_valid, rsp_reg);
        end
      end
    end
  end

  task automatic step(input bit iv, input int ir, input int ia,
                      input bit sv, input int sa,
                      input bit cv, input int cr, input bit ehit, input string tag);
    @(negedge clk);
    ins_valid = iv; ins_reg = 7'(ir); ins_addr = 32'(ia);
    st_valid  = sv; st_addr = 32'(sa);
    chk_valid = cv; chk_reg = 7'(cr);
    if (cv) begin
      exp_t e;
      e.due = cyc + 1; e.hit = ehit; e.rg = 7'(cr); e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic ins(input int r, input int a);
    step(1, r, a, 0, 0, 0, 0, 0, "");
  endtask
  task automatic st(input int a);
    step(0, 0, 0, 1, a, 0, 0, 0, "");
  endtask
  task automatic chk(input int r, input bit h, input string tag);
    step(0, 0, 0, 0, 0, 1, r, h, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (rsp_valid || reload_req) begin
      n_fail++;
      $display("FAIL R1: valid=%0b reload=%0b after reset, expected 0 0", rsp_valid, reload_req);
    end
    chk(9, 0, "R1");                       // empty table
    chk(5, 0, "R3");
    ins(1, 'h100); chk(1, 1, "R2");
    chk(1, 0, "R5");                       // consumed
    ins(2, 'h200); st('h205); chk(2, 0, "R4");  // same doubleword
    ins(3, 'h300); st('h308); chk(3, 1, "R4");  // next doubleword
    ins(4, 'h400); ins(4, 'h500); st('h400); chk(4, 1, "R6");
    ins(4, 'h600); ins(4, 'h700); st('h700); chk(4, 0, "R6");
    step(1, 6, 'h800, 1, 'h800, 0, 0, 0, ""); chk(6, 1, "R8");
    ins(7, 'h900); step(0, 0, 0, 1, 'h900, 1, 7, 0, "R9");
    ins(8, 'hA00); step(1, 8, 'hB00, 0, 0, 1, 8, 1, "R10");
    chk(8, 1, "R10");
    // Fill all 16 slots, then overflow by one.
    for (int k = 0; k < 16; k++) ins(20 + k, 'h1000 + 16 * k);
    ins(36, 'h2000);
    chk(20, 0, "R7");                      // oldest evicted
    chk(21, 1, "R7");                      // frees one slot
    ins(37, 'h2100);
    chk(22, 1, "R12");                     // no eviction on reuse
    for (int k = 23; k <= 37; k++) chk(k, 1, "R12");
    chk(37, 0, "R5");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule